// File: doc/BRIEF.md
# Dual-Edge Input Capture Register

This block takes a data bus (one bit by default) and samples it on the rising edge, the falling edge, or both edges of one clock. It hands the samples to downstream logic on two outputs, `q1` and `q2`. In double-rate operation the rising-edge sample travels on `q1` and the falling-edge sample travels on `q2`. A static alignment parameter sets when each output changes relative to the clock. The receiver can see each sample as soon as it is taken, have the falling sample moved onto the rising edge, or have both samples re-timed so that they change together as a matched pair.

In single-rate operation only one edge samples, and a parameter picks which one. The path fed by the unused edge stays at zero. An active-low reset clears every register. It is applied asynchronously, and the upstream reset logic releases it in step with the clock. A clock enable freezes every register.

Top module: `ddr_in_capture`

## Requirements
- R1: With `DDR_EN`=1, every clock period yields two samples: the value of `d` at the rising edge reaches `q1` and the value at the following falling edge reaches `q2`.
- R2: With `DDR_EN`=0 and `SDR_FALL`=0, only rising edges sample. `q1` follows the rising samples and `q2` stays 0.
- R3: With `DDR_EN`=0 and `SDR_FALL`=1, only falling edges sample. `q2` carries the falling samples and `q1` stays 0.
- R4: With `MODE`=0 (opposite edge), `q1` takes the rising sample at that rising edge and `q2` takes the falling sample at that falling edge. `q1` never changes on a falling edge.
- R5: With `MODE`=1 (same edge), `q1` behaves as in R4. The falling sample is held and appears on `q2` at the next rising edge, so `q2` changes only on rising edges.
- R6: With `MODE`=2 (same edge, pipelined), both outputs change only on rising edges. After rising edge k+1, `q1` shows the sample from rising edge k and `q2` shows the sample from the falling edge between k and k+1.
- R7: While `rst_n` is 0, all capture and holding registers and both outputs are 0, regardless of the clock.
- R8: When `ce` is 0 at an edge, no register changes at that edge. Values of `d` presented only while `ce` is 0 never reach the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| ce | input | 1 | Clock enable for every register |
| d | input | W | Data to be sampled |
| q1 | output | W | Rising-edge sample path |
| q2 | output | W | Falling-edge sample path |

## Verification
The hardest case to reach is the same-edge mode's hidden holding register. Its content appears on `q2` one rising edge late, so an error there only shows up if the falling samples differ from the rising samples in both neighbouring periods. The stimulus therefore sets `d` to one value just before each rising edge and to an independent value just before each falling edge. It does so for every alignment mode at once, and it places enable-low periods and a mid-stream reset between the pairs. Every output is sampled just before the next rising edge, against a per-instance queue of expected pairs.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
  // Alignment mode encodings (value of the MODE parameter)
  localparam int ALIGN_OPP  = 0;  // outputs change on their own edge
  localparam int ALIGN_SAME = 1;  // falling sample moved to the rising edge
  localparam int ALIGN_PIPE = 2;  // both samples moved, matched pair

  function automatic bit mode_ok(input int m);
    return (m >= ALIGN_OPP) && (m <= ALIGN_PIPE);
  endfunction
endpackage

// File: rtl/ddr_cap_edge.sv
module ddr_cap_edge #(
  parameter int W      = 1,
  parameter bit FALL   = 1'b0,
  parameter bit ACTIVE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         load;
  logic [W-1:0] cap_r;
  logic [W-1:0] cap_nxt;

  assign load = ce & ACTIVE;

  always_comb begin
    cap_nxt = cap_r;
    if (load) cap_nxt = d;
  end

  generate
    if (FALL) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_r <= '0;
        else        cap_r <= cap_nxt;
      end

      // R8: enable low freezes the falling-edge capture
      a_r8_hold_fall: assert property (@(negedge clk) disable iff (!rst_n)
        !ce |=> $stable(cap_r))
        else $error("a_r8_hold_fall");

      // R7: first falling edge after reset sees a cleared register
      a_r7_clear_fall: assert property (@(negedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cap_r == '0)
        else $error("a_r7_clear_fall");
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_r <= '0;
        else        cap_r <= cap_nxt;
      end

      // R8: enable low freezes the rising-edge capture
      a_r8_hold_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(cap_r))
        else $error("a_r8_hold_rise");

      // R7: first rising edge after reset sees a cleared register
      a_r7_clear_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cap_r == '0)
        else $error("a_r7_clear_rise");
    end
  endgenerate

  assign q = cap_r;
endmodule

// File: rtl/ddr_cap_align.sv
module ddr_cap_align
  import ddr_cap_pkg::*;
#(
  parameter int W    = 1,
  parameter int MODE = ALIGN_SAME
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] rise_q,
  input  logic [W-1:0] fall_q,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2
);
  logic [W-1:0] hold_f_r;
  logic [W-1:0] hold_f_nxt;

  always_comb begin
    hold_f_nxt = hold_f_r;
    if (ce) hold_f_nxt = fall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_f_r <= '0;
    else        hold_f_r <= hold_f_nxt;
  end

  assign q2 = hold_f_r;

  generate
    if (MODE == ALIGN_PIPE) begin : g_pipe
      logic [W-1:0] hold_r_r;
      logic [W-1:0] hold_r_nxt;

      always_comb begin
        hold_r_nxt = hold_r_r;
        if (ce) hold_r_nxt = rise_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_r_r <= '0;
        else        hold_r_r <= hold_r_nxt;
      end

      assign q1 = hold_r_r;
    end else begin : g_same
      assign q1 = rise_q;
    end
  endgenerate

  // R8: the holding stage is frozen while enable is low
  a_r8_hold_align: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(hold_f_r))
    else $error("a_r8_hold_align");
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture
  import ddr_cap_pkg::*;
#(
  parameter int W        = 1,
  parameter int MODE     = ALIGN_OPP,
  parameter bit DDR_EN   = 1'b1,
  parameter bit SDR_FALL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q1,
  output logic [W-1:0] q2
);
  localparam bit RISE_ON = DDR_EN || !SDR_FALL;
  localparam bit FALL_ON = DDR_EN || SDR_FALL;

  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  initial assert (mode_ok(MODE)) else $error("MODE out of range");

  ddr_cap_edge #(.W(W), .FALL(1'b0), .ACTIVE(RISE_ON)) u_rise (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q(rise_q)
  );

  ddr_cap_edge #(.W(W), .FALL(1'b1), .ACTIVE(FALL_ON)) u_fall (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q(fall_q)
  );

  generate
    if (MODE == ALIGN_OPP) begin : g_opp
      assign q1 = rise_q;
      assign q2 = fall_q;
    end else begin : g_aligned
      ddr_cap_align #(.W(W), .MODE(MODE)) u_align (
        .clk(clk), .rst_n(rst_n), .ce(ce),
        .rise_q(rise_q), .fall_q(fall_q), .q1(q1), .q2(q2)
      );
    end
  endgenerate

  // Output values seen at the most recent falling edge, checker use only
  logic [W-1:0] seen_q1;
  logic [W-1:0] seen_q2;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q1 <= '0;
      seen_q2 <= '0;
    end else begin
      seen_q1 <= q1;
      seen_q2 <= q2;
    end
  end

  // R4: q1 never moves on a falling edge
  a_r4_q1_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    q1 == seen_q1)
    else $error("a_r4_q1_rise_only");

  generate
    if (MODE != ALIGN_OPP) begin : g_chk_aligned
      // R5/R6: q2 never moves on a falling edge once aligned
      a_r6_q2_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        q2 == seen_q2)
        else $error("a_r6_q2_rise_only");
    end
    if (!DDR_EN && !SDR_FALL) begin : g_chk_sdr_r
      // R2: the falling path stays idle
      a_r2_q2_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q2 == '0)
        else $error("a_r2_q2_idle");
    end
    if (!DDR_EN && SDR_FALL) begin : g_chk_sdr_f
      // R3: the rising path stays idle
      a_r3_q1_idle: assert property (@(negedge clk) disable iff (!rst_n)
        q1 == '0)
        else $error("a_r3_q1_idle");
    end
  endgenerate
endmodule

// File: tb/tb_ddr_in_capture.sv
module tb_ddr_in_capture;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ce;
  logic [0:0] d;
  logic [0:0] o_q1, o_q2, s_q1, s_q2, p_q1, p_q2, r_q1, r_q2, f_q1, f_q2;

  always #(CLK_P/2) clk = ~clk;

  ddr_in_capture #(.W(1), .MODE(0), .DDR_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q1(o_q1), .q2(o_q2));
  ddr_in_capture #(.W(1), .MODE(1), .DDR_EN(1'b1)) dut_same (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q1(s_q1), .q2(s_q2));
  ddr_in_capture #(.W(1), .MODE(2), .DDR_EN(1'b1)) dut_pipe (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q1(p_q1), .q2(p_q2));
  ddr_in_capture #(.W(1), .MODE(0), .DDR_EN(1'b0), .SDR_FALL(1'b0)) dut_sdr_r (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q1(r_q1), .q2(r_q2));
  ddr_in_capture #(.W(1), .MODE(1), .DDR_EN(1'b0), .SDR_FALL(1'b1)) dut_sdr_f (
    .clk(clk), .rst_n(rst_n), .ce(ce), .d(d), .q1(f_q1), .q2(f_q2));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string ph = "R1";

  logic [1:0] q_opp[$], q_same[$], q_pipe[$], q_sr[$], q_sf[$];
  logic [1:0] l_opp, l_same, l_pipe, l_sr, l_sf;
  logic pa, pb;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_model();
    pa = 1'b0; pb = 1'b0;
    l_opp = '0; l_same = '0; l_pipe = '0; l_sr = '0; l_sf = '0;
  endtask

  task automatic push_last();
    q_opp.push_back(l_opp);  q_same.push_back(l_same); q_pipe.push_back(l_pipe);
    q_sr.push_back(l_sr);    q_sf.push_back(l_sf);
  endtask

  // a is sampled at the rising edge, b at the next falling edge
  task automatic drive_pair(input logic a, input logic b);
    @(negedge clk); #2; d = a; ce = 1'b1;
    @(posedge clk); #2; d = b;
    l_opp  = {a, b};
    l_same = {a, pb};
    l_pipe = {pa, pb};
    l_sr   = {a, 1'b0};
    l_sf   = {1'b0, pb};
    pa = a; pb = b;
    push_last();
  endtask

  // same timing with enable low: nothing may move
  task automatic hold_pair(input logic a, input logic b);
    @(negedge clk); #2; d = a; ce = 1'b0;
    @(posedge clk); #2; d = b;
    push_last();
  endtask

  task automatic check_zero(input string tag);
    check({tag, " R7 opposite"}, {o_q1, o_q2}, 2'b00);
    check({tag, " R7 same"},     {s_q1, s_q2}, 2'b00);
    check({tag, " R7 pipe"},     {p_q1, p_q2}, 2'b00);
    check({tag, " R7 sdr-r"},    {r_q1, r_q2}, 2'b00);
    check({tag, " R7 sdr-f"},    {f_q1, f_q2}, 2'b00);
  endtask

  // monitor: sample 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk); #4;
      if (q_opp.size() > 0) begin
        check({ph, " R4 R1 opposite"}, {o_q1, o_q2}, q_opp.pop_front());
        check({ph, " R5 same-edge"},   {s_q1, s_q2}, q_same.pop_front());
        check({ph, " R6 pipelined"},   {p_q1, p_q2}, q_pipe.pop_front());
        check({ph, " R2 sdr-rise"},    {r_q1, r_q2}, q_sr.pop_front());
        check({ph, " R3 sdr-fall"},    {f_q1, f_q2}, q_sf.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    rst_n = 1'b0; ce = 1'b0; d = '0;
    clear_model();
    #12;
    check_zero("reset");
    #10; rst_n = 1'b1;   // 2 ns after a falling edge

    ph = "R1 pattern";
    drive_pair(1'b1, 1'b0);
    drive_pair(1'b0, 1'b1);
    drive_pair(1'b1, 1'b1);
    drive_pair(1'b0, 1'b0);
    drive_pair(1'b1, 1'b0);
    lf = 8'hA5;
    for (int i = 0; i < 24; i++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      drive_pair(lf[0], lf[3]);
    end

    ph = "R8 ce-low";
    hold_pair(~pa, ~pb);
    hold_pair(pa, ~pb);
    hold_pair(~pa, pb);
    ph = "R8 resume";
    drive_pair(1'b0, 1'b1);
    drive_pair(1'b1, 1'b0);
    drive_pair(1'b1, 1'b1);

    wait (q_opp.size() == 0);
    @(posedge clk); #2;
    rst_n = 1'b0; ce = 1'b0;
    #1;
    check_zero("mid-run");
    @(negedge clk); #2;
    rst_n = 1'b1;
    clear_model();

    ph = "R7 after-reset";
    drive_pair(1'b1, 1'b1);
    drive_pair(1'b0, 1'b1);
    drive_pair(1'b1, 1'b0);
    drive_pair(1'b0, 1'b0);

    wait (q_opp.size() == 0);
    #(CLK_P);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule